// File: doc/BRIEF.md
# Read-Capture Delay Calibrator for a Quad SPI Flash Controller

This block finds the point at which a quad SPI NOR flash controller should sample returning read data. The sampling point is set as a count of fast reference-clock cycles added after the serial clock edge. The reference clock runs at least four times faster than the serial clock, so one step is a fraction of one serial bit. When a high serial rate needs a looped-back capture clock in SPI mode 0, this trained count is the knob that positions the sample inside the data eye.

On a start request the calibrator sends a Read ID command (opcode 0x9F) to a flash transaction engine once for each delay setting, in ascending order from 0 to 15. The trial delay travels with each command. It compares the three returned ID bytes with an expected ID and records which settings pass. It then picks the longest run of consecutive passing settings and programs the result delay to that run's centre. A run shorter than three settings is treated as a failed calibration. A bypass input skips training and forces the delay to zero. Every run ends with a single-cycle done pulse.

The controller runs in five named states. `S_IDLE` waits for start and moves to `S_FINISH` (bypass) or to `S_ISSUE` (sweep). `S_ISSUE` holds the command until it is accepted and then moves to `S_WAIT`. `S_WAIT` waits for the response and goes back to `S_ISSUE` for the next delay, or to `S_DECIDE` after delay 15. `S_DECIDE` commits the result or the failure and moves to `S_FINISH`. `S_FINISH` raises done for one cycle and returns to `S_IDLE`.

Top module: `rdcap_cal`

## Requirements
- R1: After reset, `dly_out` is 0, and `cal_fail`, `done` and `cmd_valid` are all 0.
- R2: A non-bypass run issues exactly 16 commands. Each carries `cmd_opcode` = 0x9F, and their `cmd_dly` values are 0,1,...,15 in that order.
- R3: `cmd_valid` and `cmd_dly` stay stable until `cmd_ready` is seen high. No new command is issued before the response to the previous one arrives on `rsp_valid`.
- R4: A trial passes only when all 24 bits of `rsp_id` equal `exp_id`. A difference in any single bit of any of the three bytes makes it fail.
- R5: The chosen window is the longest run of consecutive passing delays. When several runs tie for longest, the one with the lowest start wins.
- R6: The result delay is `start + (len-1)/2` of the chosen window. For an even length, this is the lower of the two centre settings.
- R7: If the chosen window is shorter than 3 settings (including no passes), `cal_fail` goes to 1 and `dly_out` keeps its previous value.
- R8: A start with `bypass` high issues no command, sets `dly_out` to 0 and clears `cal_fail`.
- R9: Each start accepted in `S_IDLE` produces exactly one `done` pulse, one cycle wide, whether the run passes or fails. `dly_out` and `cal_fail` already hold the new result in that cycle.
- R10: `cal_fail` shows the outcome of the most recent run. A later passing run or bypass run clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calibration (accepted in idle) |
| bypass | input | 1 | Skip training and force delay 0 |
| exp_id | input | 24 | Expected three-byte ID |
| cmd_ready | input | 1 | Engine accepts the pending command |
| rsp_valid | input | 1 | Response for the outstanding command |
| rsp_id | input | 24 | Three ID bytes returned by the engine |
| cmd_valid | output | 1 | Command request to the engine |
| cmd_opcode | output | 8 | Command opcode (Read ID) |
| cmd_dly | output | 4 | Trial capture delay for this command |
| dly_out | output | 4 | Trained capture delay |
| cal_fail | output | 1 | Last run found no valid window |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The response for delay 15 updates the window tracker on the same edge that ends the sweep. A run that is still open at that point must therefore be closed and compared against the best run within that single edge. The bench provokes this with passing runs that end at setting 15: the three settings 13 to 15, a fully passing sweep, and random runs placed against the top. It judges the outcome by comparing `dly_out` and `cal_fail` at the done pulse with a centre computed independently in the bench from the pass mask. Random `cmd_ready` back-pressure and random response latency move these edges relative to each other.

// File: rtl/rdcap_pkg.sv
package rdcap_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_DECIDE,
        S_FINISH
    } cal_state_t;

endpackage

// File: rtl/rdcap_idcmp.sv
module rdcap_idcmp #(
    parameter int NBYTES = 3
) (
    input  logic [NBYTES*8-1:0] got,
    input  logic [NBYTES*8-1:0] want,
    output logic                match
);
    logic [NBYTES-1:0] byte_eq;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign byte_eq[b] = (got[b*8 +: 8] == want[b*8 +: 8]);
    end

    assign match = &byte_eq;
endmodule

// File: rtl/rdcap_window.sv
module rdcap_window #(
    parameter int DLY_W = 4,
    localparam int LEN_W = DLY_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sample,
    input  logic             pass,
    input  logic [DLY_W-1:0] idx,
    output logic [DLY_W-1:0] best_start,
    output logic [LEN_W-1:0] best_len
);
    logic [DLY_W-1:0] run_start;
    logic [LEN_W-1:0] run_len;
    logic [DLY_W-1:0] cur_start;
    logic [LEN_W-1:0] cur_len;

    // start of the run that includes this sample
    assign cur_start = (run_len == '0) ? idx : run_start;
    assign cur_len   = run_len + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_start  <= '0;
            run_len    <= '0;
            best_start <= '0;
            best_len   <= '0;
        end else if (clr) begin
            run_start  <= '0;
            run_len    <= '0;
            best_start <= '0;
            best_len   <= '0;
        end else if (sample) begin
            if (pass) begin
                run_start <= cur_start;
                run_len   <= cur_len;
                // strict compare keeps the lowest-start run on a tie (R5)
                if (cur_len > best_len) begin
                    best_start <= cur_start;
                    best_len   <= cur_len;
                end
            end else begin
                run_len <= '0;
            end
        end
    end

    // R5: the recorded best window is never shorter than the open run
    p_best_covers_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        best_len >= run_len);

    // R5: a failing sample closes the open run
    p_fail_closes_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !pass && !clr) |=> (run_len == '0));
endmodule

// File: rtl/rdcap_centre.sv
module rdcap_centre #(
    parameter int DLY_W = 4,
    parameter int MIN_WIN = 3,
    localparam int LEN_W = DLY_W + 1
) (
    input  logic [DLY_W-1:0] win_start,
    input  logic [LEN_W-1:0] win_len,
    output logic [DLY_W-1:0] centre,
    output logic             win_ok
);
    logic [LEN_W-1:0] span;

    assign span   = win_len - 1'b1;
    // lower middle for even lengths (R6)
    assign centre = DLY_W'({1'b0, win_start} + (span >> 1));
    assign win_ok = (win_len >= LEN_W'(MIN_WIN));
endmodule

// File: rtl/rdcap_cal.sv
module rdcap_cal
    import rdcap_pkg::*;
#(
    parameter int          DLY_W    = 4,
    parameter int          ID_BYTES = 3,
    parameter int          MIN_WIN  = 3,
    parameter logic [7:0]  RDID_OP  = 8'h9F
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic                  bypass,
    input  logic [ID_BYTES*8-1:0] exp_id,
    input  logic                  cmd_ready,
    input  logic                  rsp_valid,
    input  logic [ID_BYTES*8-1:0] rsp_id,
    output logic                  cmd_valid,
    output logic [7:0]            cmd_opcode,
    output logic [DLY_W-1:0]      cmd_dly,
    output logic [DLY_W-1:0]      dly_out,
    output logic                  cal_fail,
    output logic                  done
);
    localparam int               LEN_W = DLY_W + 1;
    localparam logic [DLY_W-1:0] LAST  = {DLY_W{1'b1}};

    cal_state_t       state, state_nx;
    logic [DLY_W-1:0] trial;
    logic [DLY_W-1:0] dly_q;
    logic             fail_q;

    logic             id_match;
    logic             go;
    logic             take_rsp;
    logic [DLY_W-1:0] best_start;
    logic [LEN_W-1:0] best_len;
    logic [DLY_W-1:0] centre;
    logic             win_ok;

    assign go       = (state == S_IDLE) && start;
    assign take_rsp = (state == S_WAIT) && rsp_valid;

    rdcap_idcmp #(.NBYTES(ID_BYTES)) u_cmp (
        .got   (rsp_id),
        .want  (exp_id),
        .match (id_match)
    );

    rdcap_window #(.DLY_W(DLY_W)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (go),
        .sample     (take_rsp),
        .pass       (id_match),
        .idx        (trial),
        .best_start (best_start),
        .best_len   (best_len)
    );

    rdcap_centre #(.DLY_W(DLY_W), .MIN_WIN(MIN_WIN)) u_ctr (
        .win_start (best_start),
        .win_len   (best_len),
        .centre    (centre),
        .win_ok    (win_ok)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = bypass ? S_FINISH : S_ISSUE;
            S_ISSUE:  if (cmd_ready) state_nx = S_WAIT;
            S_WAIT:   if (rsp_valid) state_nx = (trial == LAST) ? S_DECIDE : S_ISSUE;
            S_DECIDE: state_nx = S_FINISH;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trial  <= '0;
            dly_q  <= '0;
            fail_q <= 1'b0;
        end else begin
            if (go) begin
                trial  <= '0;
                fail_q <= 1'b0;
                if (bypass) dly_q <= '0;
            end
            if (take_rsp && (trial != LAST)) trial <= trial + 1'b1;
            if (state == S_DECIDE) begin
                if (win_ok) dly_q  <= centre;
                else        fail_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_valid  = (state == S_ISSUE);
        cmd_opcode = RDID_OP;
        cmd_dly    = trial;
        done       = (state == S_FINISH);
        dly_out    = dly_q;
        cal_fail   = fail_q;
    end

    // R9: done lasts exactly one cycle
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3: a pending command holds until accepted
    p_cmd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_dly)));

    // R7: entering failure leaves the delay untouched
    p_fail_keeps_dly_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_fail) |-> $stable(dly_out));

    // R7: a failed result means the tracked window was too short
    p_fail_short_win_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cal_fail) |-> (best_len < LEN_W'(MIN_WIN)));

    // R8: bypass forces delay zero and clears the failure flag
    p_bypass_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (go && bypass) |=> (dly_out == '0 && !cal_fail && done));
endmodule

// File: tb/rdcap_cal_test.sv
module rdcap_cal_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        bypass = 1'b0;
    logic [23:0] exp_id = 24'hC2_25_3A;
    logic        cmd_ready = 1'b0;
    logic        rsp_valid = 1'b0;
    logic [23:0] rsp_id = '0;
    logic        cmd_valid;
    logic [7:0]  cmd_opcode;
    logic [3:0]  cmd_dly;
    logic [3:0]  dly_out;
    logic        cal_fail;
    logic        done;

    int checks = 0;
    int errors = 0;

    logic [15:0] g_mask;
    int          n_cmds;
    int          next_idx;
    int          order_bad;
    int          op_bad;
    int          overlap_bad;
    logic [3:0]  prev_dly;

    always #5 clk = ~clk;

    rdcap_cal uut (
        .clk(clk), .rst_n(rst_n), .start(start), .bypass(bypass),
        .exp_id(exp_id), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
        .rsp_id(rsp_id), .cmd_valid(cmd_valid), .cmd_opcode(cmd_opcode),
        .cmd_dly(cmd_dly), .dly_out(dly_out), .cal_fail(cal_fail), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // expected {fail, delay} from a pass mask and the delay before the run
    function automatic logic [4:0] model(input logic [15:0] m, input logic [3:0] prev);
        int rs = 0, rl = 0, bs = 0, bl = 0;
        for (int i = 0; i < 16; i++) begin
            if (m[i]) begin
                if (rl == 0) rs = i;
                rl++;
                if (rl > bl) begin bl = rl; bs = rs; end
            end else rl = 0;
        end
        if (bl < 3) return {1'b1, prev};
        return {1'b0, 4'(bs + (bl - 1) / 2)};
    endfunction

    // flash engine model: random ready and response latency
    initial begin
        forever begin
            @(negedge clk);
            cmd_ready = 1'($urandom % 2);
            if (cmd_valid && cmd_ready) begin
                automatic logic [3:0] d = cmd_dly;
                automatic int lat = 1 + int'($urandom % 4);
                n_cmds++;
                if (cmd_opcode != 8'h9F) op_bad++;
                if (int'(d) != next_idx) order_bad++;
                next_idx++;
                @(negedge clk);
                cmd_ready = 1'b0;
                for (int k = 1; k < lat; k++) begin
                    @(negedge clk);
                    if (cmd_valid) overlap_bad++;
                end
                rsp_valid = 1'b1;
                rsp_id = g_mask[d] ? exp_id : exp_id ^ (24'd1 << ($urandom % 24));
                @(negedge clk);
                rsp_valid = 1'b0;
            end
        end
    end

    task automatic run_cal(input logic [15:0] m, input bit byp, input string tag);
        logic [4:0] e;
        int t;
        g_mask = m;
        n_cmds = 0; next_idx = 0; order_bad = 0; op_bad = 0; overlap_bad = 0;
        e = byp ? 5'b0_0000 : model(m, prev_dly);
        @(negedge clk);
        start = 1'b1; bypass = byp;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 3000) begin @(negedge clk); t++; end
        check(done == 1'b1, {"R9 done seen ", tag}, int'(done), 1);
        check(cal_fail == e[4], {"R7/R10 fail flag ", tag}, int'(cal_fail), int'(e[4]));
        check(dly_out == e[3:0], {"R5/R6 delay ", tag}, int'(dly_out), int'(e[3:0]));
        @(negedge clk);
        check(done == 1'b0, {"R9 one-cycle done ", tag}, int'(done), 0);
        if (byp) begin
            check(n_cmds == 0, {"R8 no commands in bypass ", tag}, n_cmds, 0);
        end else begin
            check(n_cmds == 16, {"R2 command count ", tag}, n_cmds, 16);
            check(order_bad == 0 && op_bad == 0, {"R2 order/opcode ", tag}, order_bad + op_bad, 0);
            check(overlap_bad == 0, {"R3 one outstanding ", tag}, overlap_bad, 0);
        end
        prev_dly = dly_out;
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        prev_dly = 4'd0;
        repeat (3) @(negedge clk);
        check(dly_out == 0, "R1 reset delay", int'(dly_out), 0);
        check({cal_fail, done, cmd_valid} == 3'b000, "R1 reset flags",
              int'({cal_fail, done, cmd_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cmd_valid == 1'b0, "R1 idle after reset", int'(cmd_valid), 0);

        run_cal(16'hFFFF, 1'b0, "all pass R6");      // 7
        run_cal(16'h0007, 1'b0, "low edge");          // 1
        run_cal(16'hE000, 1'b0, "ends at 15 R5");     // 14
        run_cal(16'h0180, 1'b0, "two only R7");       // fail, keep 14
        run_cal(16'h0F0F, 1'b0, "tie R5");            // 1
        run_cal(16'h0000, 1'b0, "none R7");           // fail, keep 1
        run_cal(16'h1F03, 1'b0, "longer later R5");   // 10, clears fail R10
        run_cal(16'h01E0, 1'b0, "even len R6");       // 6
        run_cal(16'h5555, 1'b0, "R4 alternating");    // fail
        run_cal(16'h00F0, 1'b1, "bypass R8");         // 0
        run_cal(16'h0380, 1'b0, "after bypass");      // 8

        for (int n = 0; n < 14; n++) begin
            logic [15:0] m;
            if (n % 2 == 0) begin
                int s = int'($urandom % 16);
                int l = 1 + int'($urandom % 8);
                m = '0;
                for (int i = s; i < s + l && i < 16; i++) m[i] = 1'b1;
                m = m | (16'($urandom) & 16'($urandom) & 16'($urandom));
            end else begin
                m = 16'($urandom);
            end
            run_cal(m, ($urandom % 8) == 0, "random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule